// File: doc/BRIEF.md
# Converter Sample Serial Link

This block sits between a baseband modem and a data-converter front end and carries converter samples over two independent serial channels. The transmit channel takes a serial bit stream and a conversion strobe from the modem, rebuilds each 10-bit sample and hands it to the DAC side as a parallel word with a one-cycle valid pulse. The receive channel takes parallel 10-bit ADC samples and sends them to the modem serially, with a strobe that marks where each sample starts.

Each sample occupies a fixed slot of 16 channel clocks. The strobe is high for the first clock of the slot. The sample bits follow MSB first in slot positions 0 to 9, and positions 10 to 15 are padding. A 19.2 MHz channel clock therefore carries 1.2 Msps. Each direction has its own clock, its own active-low asynchronous reset and its own active-high power-down input. Either channel can be powered down while the other keeps running.

Top module: `conv_sample_link`

## Requirements
- R1: While `rx_pdn` is low, the receive channel raises `rx_conv` once every 16 `rx_clk` cycles. The first slot starts at the first `rx_clk` edge at which the channel is out of reset and `rx_pdn` is low.
- R2: `rx_conv` is high for exactly one cycle, at slot position 0. In that cycle `rx_sdata` carries bit 9 (the MSB) of the latched sample, and positions 1 to 9 carry bits 8 down to 0 in order.
- R3: `rx_sdata` is low in slot positions 10 to 15.
- R4: The receive sample is the value of `adc_data` at the `rx_clk` edge that starts the slot. Later changes on `adc_data` within the slot do not alter the bits being sent.
- R5: From the cycle after an edge at which `rx_pdn` is high, `rx_conv` and `rx_sdata` are low. The slot count is discarded, and a fresh slot starts at the first edge with `rx_pdn` low.
- R6: On transmit, the bit sampled on `tx_sdata` together with `tx_conv` high is bit 9 (the MSB), and the next 9 `tx_clk` edges supply bits 8 down to 0. Bits at positions 10 to 15, and bits sent while no slot is open, are ignored.
- R7: `dac_valid` is high for exactly one cycle, the cycle after the edge that samples bit 0. `dac_data` takes the new sample in that cycle and keeps it until the next valid pulse, a power-down or a reset.
- R8: A `tx_conv` high at any edge starts a new sample at position 0. Any partly assembled sample is dropped and produces no valid pulse.
- R9: From the cycle after an edge at which `tx_pdn` is high, `dac_valid` and `dac_data` are zero. Any partial sample is discarded, and serial data is ignored until the first `tx_conv` after `tx_pdn` returns low.
- R10: The channels are independent. Power-down or activity on one channel does not change the outputs of the other.
- R11: While its reset input is low, each channel holds its outputs at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tx_clk | input | 1 | Transmit channel clock |
| tx_rst_n | input | 1 | Transmit channel asynchronous reset, active low |
| tx_pdn | input | 1 | Transmit power-down, active high |
| tx_conv | input | 1 | Transmit conversion strobe from the modem, marks slot start |
| tx_sdata | input | 1 | Transmit serial data from the modem |
| dac_data | output | 10 | Assembled sample for the DAC |
| dac_valid | output | 1 | One-cycle pulse when `dac_data` holds a new sample |
| rx_clk | input | 1 | Receive channel clock |
| rx_rst_n | input | 1 | Receive channel asynchronous reset, active low |
| rx_pdn | input | 1 | Receive power-down, active high |
| adc_data | input | 10 | Parallel sample from the ADC |
| rx_conv | output | 1 | Receive conversion strobe to the modem, marks slot start |
| rx_sdata | output | 1 | Receive serial data to the modem |

## Verification
The assertions assume the sample is at least two bits wide and no wider than the slot. Under that assumption a strobe can never complete a sample in its own cycle, and the padding positions exist. They also assume the inputs of each channel change only away from that channel's rising clock edge. The bench drives every input on the falling edge of its own clock. It also sends strobes at arbitrary positions: mid-slot, on the last data bit, and during power-down. The transmit rules are therefore exercised without relying on a well-formed modem.

// File: rtl/conv_link_pkg.sv
package conv_link_pkg;
    // Default geometry of one converter slot
    localparam int unsigned SAMPLE_W_DEF = 10;
    localparam int unsigned SLOT_LEN_DEF = 16;
endpackage

// File: rtl/conv_tx_deser.sv
module conv_tx_deser #(
    parameter int unsigned SAMPLE_W = conv_link_pkg::SAMPLE_W_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pdn,
    input  logic                strobe,
    input  logic                sdata,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic                valid_o
);
    localparam int unsigned CNT_W = $clog2(SAMPLE_W + 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0]    cnt;    // 0 = no slot open, else bits gathered
        logic [SAMPLE_W-1:0] shift;
        logic [SAMPLE_W-1:0] sample;
        logic                valid;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (pdn) begin
            st_d = '0;
        end else if (strobe) begin
            st_d.shift = {{(SAMPLE_W-1){1'b0}}, sdata};
            st_d.cnt   = CNT_ONE;
        end else if (st_q.cnt != '0) begin
            st_d.shift = {st_q.shift[SAMPLE_W-2:0], sdata};
            if (st_q.cnt == CNT_LAST) begin
                st_d.sample = {st_q.shift[SAMPLE_W-2:0], sdata};
                st_d.valid  = 1'b1;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample_o = st_q.sample;
    assign valid_o  = st_q.valid;

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_sample_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sample_o) |-> (valid_o || sample_o == '0));

    assert_pdn_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pdn |=> (!valid_o && sample_o == '0));

    assert_restart_no_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !valid_o);
endmodule

// File: rtl/conv_rx_ser.sv
module conv_rx_ser #(
    parameter int unsigned SAMPLE_W = conv_link_pkg::SAMPLE_W_DEF,
    parameter int unsigned SLOT_LEN = conv_link_pkg::SLOT_LEN_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pdn,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic                strobe_o,
    output logic                sdata_o
);
    localparam int unsigned POS_W = $clog2(SLOT_LEN);
    localparam logic [POS_W-1:0] POS_ONE   = POS_W'(1);
    localparam logic [POS_W-1:0] POS_LAST  = POS_W'(SLOT_LEN - 1);
    localparam logic [POS_W-1:0] POS_FPAD  = POS_W'(SAMPLE_W);

    typedef struct packed {
        logic                act;    // a slot is in progress
        logic [POS_W-1:0]    pos;    // position of the bit on the outputs
        logic [SAMPLE_W-1:0] hold;   // latched sample, shifted toward MSB
        logic                strobe;
        logic                sdata;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pdn) begin
            st_d = '0;
        end else if (!st_q.act || st_q.pos == POS_LAST) begin
            st_d.act    = 1'b1;
            st_d.pos    = '0;
            st_d.hold   = sample_i;
            st_d.strobe = 1'b1;
            st_d.sdata  = sample_i[SAMPLE_W-1];
        end else begin
            st_d.pos    = st_q.pos + POS_ONE;
            st_d.hold   = {st_q.hold[SAMPLE_W-2:0], 1'b0};
            st_d.strobe = 1'b0;
            st_d.sdata  = st_q.hold[SAMPLE_W-2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe_o = st_q.strobe;
    assign sdata_o  = st_q.sdata;

    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);

    assert_strobe_at_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> (st_q.act && st_q.pos == '0));

    assert_padding_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && st_q.pos >= POS_FPAD) |-> !sdata_o);

    assert_pdn_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pdn |=> (!strobe_o && !sdata_o && !st_q.act));
endmodule

// File: rtl/conv_sample_link.sv
module conv_sample_link #(
    parameter int unsigned SAMPLE_W = conv_link_pkg::SAMPLE_W_DEF,
    parameter int unsigned SLOT_LEN = conv_link_pkg::SLOT_LEN_DEF
) (
    input  logic                tx_clk,
    input  logic                tx_rst_n,
    input  logic                tx_pdn,
    input  logic                tx_conv,
    input  logic                tx_sdata,
    output logic [SAMPLE_W-1:0] dac_data,
    output logic                dac_valid,
    input  logic                rx_clk,
    input  logic                rx_rst_n,
    input  logic                rx_pdn,
    input  logic [SAMPLE_W-1:0] adc_data,
    output logic                rx_conv,
    output logic                rx_sdata
);
    // R10: the two channels share no state and no clock
    conv_tx_deser #(.SAMPLE_W(SAMPLE_W)) tx_i (
        .clk      (tx_clk),
        .rst_n    (tx_rst_n),
        .pdn      (tx_pdn),
        .strobe   (tx_conv),
        .sdata    (tx_sdata),
        .sample_o (dac_data),
        .valid_o  (dac_valid)
    );

    conv_rx_ser #(.SAMPLE_W(SAMPLE_W), .SLOT_LEN(SLOT_LEN)) rx_i (
        .clk      (rx_clk),
        .rst_n    (rx_rst_n),
        .pdn      (rx_pdn),
        .sample_i (adc_data),
        .strobe_o (rx_conv),
        .sdata_o  (rx_sdata)
    );

    assert_tx_reset_R11: assert property (@(posedge tx_clk)
        !tx_rst_n |-> (!dac_valid && dac_data == '0));

    assert_rx_reset_R11: assert property (@(posedge rx_clk)
        !rx_rst_n |-> (!rx_conv && !rx_sdata));
endmodule

// File: tb/conv_sample_link_tb_top.sv
module conv_sample_link_tb_top;
    localparam int W    = 10;
    localparam int SLOT = 16;

    logic tx_clk = 1'b0, rx_clk = 1'b0;
    logic tx_rst_n = 1'b0, rx_rst_n = 1'b0;
    logic tx_pdn = 1'b0, tx_conv = 1'b0, tx_sdata = 1'b0;
    logic rx_pdn = 1'b0;
    logic [W-1:0] adc_data = '0;
    logic [W-1:0] dac_data;
    logic dac_valid, rx_conv, rx_sdata;

    int n_checks = 0, n_fail = 0;

    always #4 tx_clk = ~tx_clk;
    initial begin #2; forever #4 rx_clk = ~rx_clk; end

    conv_sample_link dut_i (
        .tx_clk(tx_clk), .tx_rst_n(tx_rst_n), .tx_pdn(tx_pdn),
        .tx_conv(tx_conv), .tx_sdata(tx_sdata),
        .dac_data(dac_data), .dac_valid(dac_valid),
        .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .rx_pdn(rx_pdn),
        .adc_data(adc_data), .rx_conv(rx_conv), .rx_sdata(rx_sdata)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // ---------------- transmit reference model ----------------
    int    tx_bits[$];
    bit    tx_open = 0;
    logic  exp_valid = 0;
    logic [W-1:0] exp_dac = '0;
    string tx_tag = "R11";

    always @(posedge tx_clk or negedge tx_rst_n) begin
        if (!tx_rst_n) begin
            tx_bits.delete(); tx_open = 0;
            exp_valid <= 0; exp_dac <= '0; tx_tag = "R11";
        end else begin
            exp_valid <= 0;
            if (tx_pdn) begin
                tx_bits.delete(); tx_open = 0; exp_dac <= '0; tx_tag = "R9";
            end else if (tx_conv) begin
                tx_tag = (tx_open && tx_bits.size() > 0) ? "R8" : "R6";
                tx_bits.delete(); tx_bits.push_back(int'(tx_sdata)); tx_open = 1;
            end else if (tx_open) begin
                tx_bits.push_back(int'(tx_sdata));
                if (tx_bits.size() == W) begin
                    logic [W-1:0] v;
                    for (int i = 0; i < W; i++) v[W-1-i] = tx_bits[i][0];
                    exp_dac <= v; exp_valid <= 1; tx_open = 0; tx_tag = "R7";
                    tx_bits.delete();
                end
            end else if (tx_tag != "R9") begin
                tx_tag = "R6";
            end
        end
    end

    always @(negedge tx_clk) begin
        chk(dac_valid === exp_valid, tx_tag, "dac_valid", int'(dac_valid), int'(exp_valid));
        chk(dac_data === exp_dac, tx_tag, "dac_data", int'(dac_data), int'(exp_dac));
    end

    // ---------------- receive reference model ----------------
    int    rx_q[$];
    int    rx_phase = 0;
    bit    rx_run = 0;
    logic  exp_conv = 0, exp_sd = 0;
    string rx_tag = "R11";

    always @(posedge rx_clk or negedge rx_rst_n) begin
        if (!rx_rst_n) begin
            rx_run = 0; rx_q.delete(); exp_conv <= 0; exp_sd <= 0; rx_tag = "R11";
        end else if (rx_pdn) begin
            rx_run = 0; rx_q.delete(); exp_conv <= 0; exp_sd <= 0; rx_tag = "R5";
        end else if (!rx_run || rx_phase == SLOT - 1) begin
            rx_run = 1; rx_phase = 0; rx_q.delete();
            for (int i = W - 1; i >= 0; i--) rx_q.push_back(int'(adc_data[i]));
            for (int i = W; i < SLOT; i++) rx_q.push_back(0);
            exp_conv <= 1; exp_sd <= rx_q.pop_front()[0]; rx_tag = "R1 R2";
        end else begin
            rx_phase++;
            exp_conv <= 0; exp_sd <= rx_q.pop_front()[0];
            rx_tag = (rx_phase < W) ? "R2 R4" : "R3";
        end
    end

    always @(negedge rx_clk) begin
        // R10: rx results while the other channel is powered down
        string t;
        t = (tx_pdn && rx_rst_n && !rx_pdn) ? "R10" : rx_tag;
        chk(rx_conv === exp_conv, t, "rx_conv", int'(rx_conv), int'(exp_conv));
        chk(rx_sdata === exp_sd, t, "rx_sdata", int'(rx_sdata), int'(exp_sd));
    end

    // ---------------- transmit stimulus ----------------
    task automatic tx_slot(input logic [W-1:0] v, input int len);
        for (int p = 0; p < len; p++) begin
            @(negedge tx_clk);
            tx_conv  = (p == 0);
            tx_sdata = (p < W) ? v[W-1-p] : 1'($urandom);
        end
    endtask

    task automatic tx_idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge tx_clk); tx_conv = 0; tx_sdata = 1'($urandom);
        end
    endtask

    task automatic tx_seq();
        tx_idle(3);                    // R6: data with no slot open
        tx_slot(10'h3FF, SLOT);
        tx_slot(10'h000, SLOT);
        tx_slot(10'h2AA, SLOT);
        tx_slot(10'h155, SLOT);
        tx_slot(10'h201, SLOT);
        tx_slot(10'h1C7, 5);           // R8: partial then restart
        tx_slot(10'h0F0, SLOT);
        tx_slot(10'h3A5, W);           // R8: strobe lands on pos 10? no, next slot
        tx_slot(10'h111, W - 1);       // R8: cut before the last bit
        tx_slot(10'h2DB, SLOT);
        tx_slot(10'h36C, 6);           // R9: power down mid-sample
        @(negedge tx_clk); tx_pdn = 1;
        for (int i = 0; i < 20; i++) begin
            @(negedge tx_clk); tx_conv = 1'($urandom); tx_sdata = 1'($urandom);
        end
        @(negedge tx_clk); tx_pdn = 0; tx_conv = 0;
        tx_idle(4);                    // R9: ignored until a strobe
        tx_slot(10'h24B, SLOT);
        for (int k = 0; k < 30; k++) tx_slot(W'($urandom), SLOT);
        tx_idle(4);
    endtask

    // ---------------- receive stimulus ----------------
    task automatic rx_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge rx_clk); adc_data = W'($urandom);
        end
    endtask

    task automatic rx_seq();
        rx_cycles(5 * SLOT + 3);
        @(negedge rx_clk); rx_pdn = 1; adc_data = W'($urandom);
        rx_cycles(3);
        @(negedge rx_clk); rx_pdn = 0;
        rx_cycles(3 * SLOT + 7);
        @(negedge rx_clk); rx_pdn = 1;  // single-cycle power-down
        @(negedge rx_clk); rx_pdn = 0;
        rx_cycles(20 * SLOT);
    endtask

    initial begin
        repeat (4) @(negedge tx_clk);
        @(negedge tx_clk); tx_rst_n = 1;
        @(negedge rx_clk); rx_rst_n = 1;
        fork
            tx_seq();
            rx_seq();
        join
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge tx_clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        finish_run();
    end
endmodule